// File: doc/BRIEF.md
# Rotating-Sink Biphasic Stimulus Sequencer

This block sequences one asymmetric biphasic stimulus for an H-bridge neural stimulator. The stimulator has `NSINK` identical current sinks. Each accepted trigger starts a waveform of up to four phases:

1. A cathodic phase of T cycles, with the bridge in its forward direction and every sink conducting.
2. An optional interphase gap, with nothing conducting.
3. An anodic phase of NSINK·T cycles, with the bridge reversed and a single sink conducting.
4. An optional passive discharge, in which a shorting switch removes residual charge.

The sink used in the anodic phase moves on by one position after every complete waveform. Charge therefore balances across NSINK consecutive stimuli rather than within a single pulse, and sink mismatch averages out. One cycle with every switch and sink off sits between any two consecutive phases, so the two bridge directions never overlap.

The programmed durations are captured when a trigger is accepted. A trigger that arrives during a waveform is discarded and recorded in a sticky overrun flag.

Top module: `stim_seq`

## Requirements
- R1: A trigger seen at a clock edge while idle, with `en`=1 and `t_phase`≠0, makes `sw_cath`=1 and `sink_en` all ones from the next cycle, for exactly `t_phase` cycles.
- R2: During the anodic phase `sw_anod`=1 and `sink_en` is one-hot, with bit k set for rotation index k. The phase lasts NSINK·T cycles.
- R3: The rotation index is 0 after reset and rises by one when each waveform ends, wrapping from NSINK-1 to 0. Over NSINK waveforms every sink is used once in the anodic phase.
- R4: Exactly one cycle with all switch outputs and `sink_en` at zero lies between consecutive phases. `sw_cath` and `sw_anod` are never high together.
- R5: When `t_gap`=G>0, G cycles with everything off follow the dead cycle after the cathodic phase, then another dead cycle follows. With G=0 only one dead cycle separates the cathodic and anodic phases.
- R6: When `t_dis`=D>0, `sw_dis`=1 for D cycles after the dead cycle that follows the anodic phase, with all sinks off. With D=0 the waveform ends after that dead cycle.
- R7: A trigger at an edge where `busy`=1 does not alter the waveform. It sets `overrun`, which stays 1 until reset.
- R8: `busy` is 1 from the first cathodic cycle through the last cycle of the waveform, and 0 otherwise. While `busy`=0 all switch outputs and `sink_en` are 0.
- R9: After reset every output is 0 and `overrun` is 0.
- R10: A trigger with `en`=0 or with `t_phase`=0 starts nothing and does not set `overrun`.
- R11: Changes to `t_phase`, `t_gap` or `t_dis` during a waveform do not change that waveform's durations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Allows triggers to start a waveform |
| trig | input | 1 | Stimulus request, sampled each edge |
| t_phase | input | TW | Cathodic duration T in cycles |
| t_gap | input | TW | Interphase gap in cycles |
| t_dis | input | TW | Discharge duration in cycles |
| sw_cath | output | 1 | Bridge switches for the cathodic direction |
| sw_anod | output | 1 | Bridge switches for the reversed direction |
| sw_dis | output | 1 | Electrode shorting switch |
| sink_en | output | NSINK | Per-sink enables |
| busy | output | 1 | Waveform in progress |
| overrun | output | 1 | Sticky flag for a trigger while busy |

## Verification
The assertions make no assumption about `trig` or the timing inputs. Any trigger pattern and any duration values, including zero, are legal, because the block itself rejects a zero `t_phase` and skips empty gap and discharge phases. They do take the reset as synchronous and held for at least one edge. The stimulus drives every input just after the falling edge, so values are stable at the rising edge. It deliberately changes durations and pulses `trig` in the middle of a waveform to exercise latching and overrun.

// File: rtl/stim_seq.sv
module stim_seq #(
  parameter int NSINK = 4,
  parameter int TW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             trig,
  input  logic [TW-1:0]    t_phase,
  input  logic [TW-1:0]    t_gap,
  input  logic [TW-1:0]    t_dis,
  output logic             sw_cath,
  output logic             sw_anod,
  output logic             sw_dis,
  output logic [NSINK-1:0] sink_en,
  output logic             busy,
  output logic             overrun
);
  localparam int IW = (NSINK > 1) ? $clog2(NSINK) : 1;
  localparam int CW = TW + $clog2(NSINK + 1);

  typedef enum logic [2:0] {S_IDLE, S_CATH, S_GAP, S_ANOD, S_DIS, S_DEAD} st_t;

  st_t            st, after;
  logic [CW-1:0]  cnt, len_after;
  logic [TW-1:0]  t_r, g_r, d_r;
  logic [IW-1:0]  idx, idx_nx;
  logic           start;

  assign start  = (st == S_IDLE) && en && trig && (t_phase != '0);
  assign idx_nx = (idx == IW'(NSINK - 1)) ? '0 : idx + 1'b1;

  always_comb begin
    case (after)
      S_GAP:   len_after = CW'(g_r);
      S_ANOD:  len_after = CW'(t_r) * CW'(NSINK);
      S_DIS:   len_after = CW'(d_r);
      default: len_after = CW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      after   <= S_IDLE;
      cnt     <= '0;
      t_r     <= '0;
      g_r     <= '0;
      d_r     <= '0;
      idx     <= '0;
      overrun <= 1'b0;
    end else begin
      if (trig && st != S_IDLE) overrun <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          t_r <= t_phase;
          g_r <= t_gap;
          d_r <= t_dis;
          cnt <= CW'(t_phase) - 1'b1;
          st  <= S_CATH;
        end
        S_CATH: if (cnt == '0) begin
          st    <= S_DEAD;
          after <= (g_r != '0) ? S_GAP : S_ANOD;
        end else cnt <= cnt - 1'b1;
        S_GAP: if (cnt == '0) begin
          st    <= S_DEAD;
          after <= S_ANOD;
        end else cnt <= cnt - 1'b1;
        S_ANOD: if (cnt == '0) begin
          st    <= S_DEAD;
          after <= (d_r != '0) ? S_DIS : S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_DIS: if (cnt == '0) begin
          st  <= S_IDLE;
          idx <= idx_nx;
        end else cnt <= cnt - 1'b1;
        S_DEAD: begin
          st  <= after;
          cnt <= len_after - 1'b1;
          if (after == S_IDLE) idx <= idx_nx;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign sw_cath = (st == S_CATH);
  assign sw_anod = (st == S_ANOD);
  assign sw_dis  = (st == S_DIS);
  assign sink_en = sw_cath ? {NSINK{1'b1}} :
                   sw_anod ? (NSINK'(1) << idx) : '0;

  AST_BRIDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_cath && sw_anod)); // R4
  AST_DEAD_AFTER_CATH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_cath) |-> (!sw_anod && !sw_dis && sink_en == '0)); // R4
  AST_CATH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    sw_cath |-> (&sink_en)); // R1
  AST_ANOD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_anod |-> ($countones(sink_en) == 1)); // R2
  AST_DIS_NO_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    sw_dis |-> (sink_en == '0 && !sw_cath && !sw_anod)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sw_cath && !sw_anod && !sw_dis && sink_en == '0)); // R8
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(idx)); // R3
endmodule

// File: tb/tb_stim_seq.sv
module tb_stim_seq;
  localparam int N = 4;
  localparam int TW = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, trig = 1'b0;
  logic [TW-1:0] t_phase = '0, t_gap = '0, t_dis = '0;
  logic sw_cath, sw_anod, sw_dis, busy, overrun;
  logic [N-1:0] sink_en;

  stim_seq #(.NSINK(N), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .t_phase(t_phase),
    .t_gap(t_gap), .t_dis(t_dis), .sw_cath(sw_cath), .sw_anod(sw_anod),
    .sw_dis(sw_dis), .sink_en(sink_en), .busy(busy), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int q[$];
  int m_idx = 0;
  bit m_ovr = 0;
  string cur_req = "R9";

  // reference model, entries: 1 cathodic, 2 gap, 3 anodic, 4 discharge, 5 dead
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete(); m_idx = 0; m_ovr = 0;
    end else if (q.size() == 0) begin
      if (trig && en && t_phase != 0) begin
        for (int i = 0; i < t_phase; i++) q.push_back(1);
        q.push_back(5);
        if (t_gap != 0) begin
          for (int i = 0; i < t_gap; i++) q.push_back(2);
          q.push_back(5);
        end
        for (int i = 0; i < N * t_phase; i++) q.push_back(3);
        q.push_back(5);
        for (int i = 0; i < t_dis; i++) q.push_back(4);
      end
    end else begin
      if (trig) m_ovr = 1;
      void'(q.pop_front());
      if (q.size() == 0) m_idx = (m_idx + 1) % N;
    end
  end

  task automatic chk(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) %s actual %0h expected %0h at cycle %0d", req, cur_req, nm, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int ph;
    ph = (q.size() != 0) ? q[0] : 0;
    chk("R1", "sw_cath", sw_cath, ph == 1);
    chk("R2", "sw_anod", sw_anod, ph == 3);
    chk("R6", "sw_dis", sw_dis, ph == 4);
    chk("R3", "sink_en", sink_en, ph == 1 ? (1 << N) - 1 : ph == 3 ? (1 << m_idx) : 0);
    chk("R8", "busy", busy, q.size() != 0);
    chk("R7", "overrun", overrun, m_ovr);
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic drive_cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic fire(int t, int g, int d);
    t_phase = TW'(t); t_gap = TW'(g); t_dis = TW'(d);
    trig = 1; drive_cyc(1); trig = 0;
  endtask

  task automatic wait_idle();
    drive_cyc(1);
    while (busy) drive_cyc(1);
    drive_cyc(2);
  endtask

  initial begin
    drive_cyc(3);
    // R9 reset state
    chk("R9", "reset busy", busy, 0);
    chk("R9", "reset sink_en", sink_en, 0);
    chk("R9", "reset switches", {sw_cath, sw_anod, sw_dis}, 0);
    chk("R9", "reset overrun", overrun, 0);
    rst_n = 1; en = 1; drive_cyc(2);
    cur_req = "R1/R5/R6";
    fire(2, 3, 2); wait_idle();
    cur_req = "R10";
    en = 0; fire(3, 1, 1); drive_cyc(3);
    chk("R10", "en low busy", busy, 0);
    en = 1; fire(0, 1, 1); drive_cyc(3);
    chk("R10", "zero T busy", busy, 0);
    chk("R10", "no overrun", overrun, 0);
    cur_req = "R5 gap zero";
    fire(1, 0, 3); wait_idle();
    cur_req = "R6 dis zero";
    fire(3, 2, 0); wait_idle();
    cur_req = "R3 wrap";
    fire(1, 0, 0); wait_idle();
    fire(2, 1, 1); wait_idle();
    cur_req = "R11";
    fire(3, 2, 2);
    t_phase = 9; t_gap = 7; t_dis = 5; drive_cyc(6);
    cur_req = "R7";
    chk("R7", "overrun before", overrun, 0);
    trig = 1; drive_cyc(1); trig = 0; drive_cyc(1);
    chk("R7", "overrun set", overrun, 1);
    wait_idle();
    chk("R7", "overrun sticky", overrun, 1);
    cur_req = "R4";
    fire(4, 0, 0); wait_idle();
    for (int k = 0; k < N; k++) begin
      fire(k + 1, k % 2, (k + 1) % 2); wait_idle();
    end
    cur_req = "R9";
    rst_n = 0; drive_cyc(2);
    chk("R9", "reset clears overrun", overrun, 0);
    rst_n = 1; drive_cyc(1);
    cur_req = "R3 after reset";
    fire(1, 1, 1); wait_idle();
    finish_run();
  end
endmodule